// File: doc/BRIEF.md
# Last Floating-Point Instruction State Capture

This block keeps three pieces of state about the most recent floating-point instruction to retire that was not a control instruction: its opcode packed into 11 bits, the address of the instruction, and the address of the memory operand it touched. The retire logic pulses a strobe once per retiring floating-point instruction. With that strobe it presents the two opcode bytes, the current operating mode, the code-side address pieces (selector, offset, segment base) and, when the instruction read or wrote memory, the data-side address pieces.

Each pointer is built in a form that depends on the mode. In 64-bit mode the pointer is the raw 64-bit offset. In legacy protected or compatibility mode it is a selector beside a 32-bit offset. In real or virtual-8086 mode it is a 32-bit linear address, formed from segment base plus offset. Control instructions do not disturb the captured state. An initialize pulse clears all three fields. Results appear on registered outputs one clock after the retire edge.

Top module: `fpu_last_insn_capture`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all three outputs are cleared to zero.
- R2: On a captured retire, `last_opcode_o[10:8]` takes `opc_byte0_i[2:0]` and `last_opcode_o[7:0]` takes `opc_byte1_i`. Bits 7:3 of the first byte are discarded, so bytes D9 F8 give 11'h1F8.
- R3: A retire with `ctrl_insn_i` high leaves the opcode, instruction pointer and data pointer unchanged.
- R4: Mode 2'b00 (64-bit): the pointer equals the full 64-bit offset input, and the selector and base have no effect.
- R5: Mode 2'b01 (protected/compatibility): pointer bits 31:0 hold offset bits 31:0, bits 47:32 hold the 16-bit selector, and bits 63:48 are zero.
- R6: Modes 2'b10 (real) and 2'b11 (virtual-8086): the pointer is (base[31:0] + offset[31:0]) modulo 2^32, zero-extended to 64 bits. The selector has no effect.
- R7: The data pointer follows the R4 to R6 rules applied to the data selector, offset and base. It updates only on a captured retire with `mem_valid_i` high, and otherwise keeps its value.
- R8: An `init_i` pulse clears all three outputs at the next edge, even if a retire arrives in the same cycle.
- R9: With neither `retire_i` nor `init_i` asserted, all outputs hold their values whatever the other inputs do.
- R10: A captured retire shows up on the outputs on the first rising edge after it is sampled, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| retire_i | input | 1 | A floating-point instruction retires this cycle |
| ctrl_insn_i | input | 1 | The retiring instruction is a control instruction |
| opc_byte0_i | input | 8 | First opcode byte |
| opc_byte1_i | input | 8 | Second opcode byte |
| mode_i | input | 2 | 00 64-bit, 01 protected/compat, 10 real, 11 virtual-8086 |
| code_sel_i | input | 16 | Code segment selector |
| code_off_i | input | 64 | Instruction offset |
| code_base_i | input | 64 | Code segment base |
| mem_valid_i | input | 1 | The instruction accessed a memory operand |
| data_sel_i | input | 16 | Data segment selector |
| data_off_i | input | 64 | Memory operand offset |
| data_base_i | input | 64 | Data segment base |
| init_i | input | 1 | Initialize pulse; clears all captured state |
| last_opcode_o | output | 11 | Packed opcode of the last captured instruction |
| last_ip_o | output | 64 | Last instruction pointer |
| last_dp_o | output | 64 | Last data pointer |

## Verification
The hardest case to reach is a data pointer that has to survive several later captures which did not touch memory, or which were control instructions, sometimes in a different mode. A stale value is only visible if it differs from what a fresh capture would produce. The stimulus therefore first loads a distinctive data pointer. It then retires instructions with `mem_valid_i` low and with `ctrl_insn_i` high while every data-side input is driven to new values. It also retires a real-mode instruction whose base and offset overflow 32 bits, and it raises init in the same cycle as a retire. A behavioural model, updated on every clock, is compared with all three outputs throughout a random phase as well.

// File: rtl/lic_pkg.sv
// Shared types for the last-instruction capture block.
// Assumes a 2-bit mode code driven by the core's mode logic.
package lic_pkg;
    typedef enum logic [1:0] {
        MODE_LONG = 2'b00,
        MODE_PROT = 2'b01,
        MODE_REAL = 2'b10,
        MODE_V86  = 2'b11
    } lic_mode_e;
endpackage

// File: rtl/lic_opcode_pack.sv
// Packs the two opcode bytes into the compressed opcode field.
// Assumes the discarded high bits of the first byte are the same for
// every floating-point opcode, so nothing is lost by dropping them.
module lic_opcode_pack #(
    parameter int BYTE_W = 8,
    parameter int LO_W   = 3
) (
    input  logic [BYTE_W-1:0]      byte0_i,
    input  logic [BYTE_W-1:0]      byte1_i,
    output logic [LO_W+BYTE_W-1:0] opcode_o
);
    // Bits of the first byte that carry no information.
    logic unused_hi_bits;
    assign unused_hi_bits = ^byte0_i[BYTE_W-1:LO_W];

    // Low bits of the first byte sit above the whole second byte.
    always_comb begin
        opcode_o = {byte0_i[LO_W-1:0], byte1_i};
    end
endmodule

// File: rtl/lic_ptr_format.sv
// Builds a 64-bit pointer in the form the operating mode calls for.
// Assumes PTR_W >= SEL_W + OFF32_W and LIN_W < PTR_W.
module lic_ptr_format
    import lic_pkg::*;
#(
    parameter int PTR_W   = 64,
    parameter int SEL_W   = 16,
    parameter int OFF32_W = 32,
    parameter int LIN_W   = 32
) (
    input  lic_mode_e        mode_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [PTR_W-1:0] off_i,
    input  logic [PTR_W-1:0] base_i,
    output logic [PTR_W-1:0] ptr_o
);
    logic [LIN_W-1:0] lin_addr;
    logic             unused_base_hi;

    // Base bits above the linear width never reach the pointer.
    assign unused_base_hi = ^base_i[PTR_W-1:LIN_W];

    // Linear address wraps within LIN_W bits.
    always_comb begin
        lin_addr = base_i[LIN_W-1:0] + off_i[LIN_W-1:0];
    end

    // Mode selects the layout of the pointer.
    always_comb begin
        ptr_o = '0;
        case (mode_i)
            MODE_LONG: ptr_o = off_i;
            MODE_PROT: begin
                ptr_o[OFF32_W-1:0]       = off_i[OFF32_W-1:0];
                ptr_o[OFF32_W +: SEL_W]  = sel_i;
            end
            default:   ptr_o[LIN_W-1:0]  = lin_addr;
        endcase
    end
endmodule

// File: rtl/fpu_last_insn_capture.sv
// Holds opcode, instruction pointer and data pointer of the last
// non-control floating-point instruction to retire.
// Assumes retire_i is a one-cycle strobe per instruction and that the
// inputs beside it are valid in the same cycle.
module fpu_last_insn_capture
    import lic_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int OPC_LO  = 3,
    parameter int PTR_W   = 64,
    parameter int SEL_W   = 16,
    parameter int OFF32_W = 32,
    parameter int LIN_W   = 32,
    localparam int OPC_W  = OPC_LO + BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              retire_i,
    input  logic              ctrl_insn_i,
    input  logic [BYTE_W-1:0] opc_byte0_i,
    input  logic [BYTE_W-1:0] opc_byte1_i,
    input  logic [1:0]        mode_i,
    input  logic [SEL_W-1:0]  code_sel_i,
    input  logic [PTR_W-1:0]  code_off_i,
    input  logic [PTR_W-1:0]  code_base_i,
    input  logic              mem_valid_i,
    input  logic [SEL_W-1:0]  data_sel_i,
    input  logic [PTR_W-1:0]  data_off_i,
    input  logic [PTR_W-1:0]  data_base_i,
    input  logic              init_i,
    output logic [OPC_W-1:0]  last_opcode_o,
    output logic [PTR_W-1:0]  last_ip_o,
    output logic [PTR_W-1:0]  last_dp_o
);
    lic_mode_e        mode;
    logic [OPC_W-1:0] opc_next;
    logic [PTR_W-1:0] ip_next;
    logic [PTR_W-1:0] dp_next;
    logic             capture;

    // Decode the mode input into the shared type.
    assign mode    = lic_mode_e'(mode_i);
    // A capture is a retire that is not a control instruction.
    assign capture = retire_i && !ctrl_insn_i;

    lic_opcode_pack #(
        .BYTE_W (BYTE_W),
        .LO_W   (OPC_LO)
    ) u_opc (
        .byte0_i  (opc_byte0_i),
        .byte1_i  (opc_byte1_i),
        .opcode_o (opc_next)
    );

    lic_ptr_format #(
        .PTR_W   (PTR_W),
        .SEL_W   (SEL_W),
        .OFF32_W (OFF32_W),
        .LIN_W   (LIN_W)
    ) u_ip_fmt (
        .mode_i (mode),
        .sel_i  (code_sel_i),
        .off_i  (code_off_i),
        .base_i (code_base_i),
        .ptr_o  (ip_next)
    );

    lic_ptr_format #(
        .PTR_W   (PTR_W),
        .SEL_W   (SEL_W),
        .OFF32_W (OFF32_W),
        .LIN_W   (LIN_W)
    ) u_dp_fmt (
        .mode_i (mode),
        .sel_i  (data_sel_i),
        .off_i  (data_off_i),
        .base_i (data_base_i),
        .ptr_o  (dp_next)
    );

    // Opcode and instruction pointer: reset, init, then capture.
    always_ff @(posedge clk) begin
        if (!rst_n || init_i) begin
            last_opcode_o <= '0;
            last_ip_o     <= '0;
        end else if (capture) begin
            last_opcode_o <= opc_next;
            last_ip_o     <= ip_next;
        end
    end

    // Data pointer: as above, but only for memory-touching captures.
    always_ff @(posedge clk) begin
        if (!rst_n || init_i) begin
            last_dp_o <= '0;
        end else if (capture && mem_valid_i) begin
            last_dp_o <= dp_next;
        end
    end

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_i && ctrl_insn_i && !init_i) |=>
        ($stable(last_opcode_o) && $stable(last_ip_o) && $stable(last_dp_o))); // R3

    AST_INIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (last_opcode_o == '0 && last_ip_o == '0 && last_dp_o == '0)); // R8

    AST_DP_NO_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_i && !mem_valid_i && !init_i) |=> $stable(last_dp_o)); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!retire_i && !init_i) |=>
        ($stable(last_opcode_o) && $stable(last_ip_o) && $stable(last_dp_o))); // R9

    AST_OPC_LAYOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_i && !ctrl_insn_i && !init_i) |=>
        (last_opcode_o[BYTE_W-1:0] == $past(opc_byte1_i) &&
         last_opcode_o[OPC_W-1:BYTE_W] == $past(opc_byte0_i[OPC_LO-1:0]))); // R2

    AST_LONG_IP: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !init_i && mode_i == 2'b00) |=> last_ip_o == $past(code_off_i)); // R4
endmodule

// File: tb/fpu_last_insn_capture_tb.sv
`timescale 1ns/1ps
module fpu_last_insn_capture_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        retire, ctrl, mem_valid, init;
    logic [7:0]  b0, b1;
    logic [1:0]  mode;
    logic [15:0] csel, dsel;
    logic [63:0] coff, cbase, doff, dbase;
    logic [10:0] opc_o;
    logic [63:0] ip_o, dp_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [10:0] m_opc;
    logic [63:0] m_ip, m_dp;

    always #5 clk = ~clk;

    fpu_last_insn_capture u_dut (
        .clk(clk), .rst_n(rst_n), .retire_i(retire), .ctrl_insn_i(ctrl),
        .opc_byte0_i(b0), .opc_byte1_i(b1), .mode_i(mode),
        .code_sel_i(csel), .code_off_i(coff), .code_base_i(cbase),
        .mem_valid_i(mem_valid), .data_sel_i(dsel), .data_off_i(doff),
        .data_base_i(dbase), .init_i(init),
        .last_opcode_o(opc_o), .last_ip_o(ip_o), .last_dp_o(dp_o)
    );

    // Behavioural pointer rule from R4, R5, R6.
    function automatic logic [63:0] ref_ptr(input logic [1:0] md, input logic [15:0] s,
                                            input logic [63:0] o, input logic [63:0] b);
        longint unsigned lin;
        if (md == 2'b00) return o;
        if (md == 2'b01) return (64'(s) << 32) | (o & 64'hFFFF_FFFF);
        lin = ((b & 64'hFFFF_FFFF) + (o & 64'hFFFF_FFFF)) % 64'h1_0000_0000;
        return lin;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: model reacts to the inputs held across the edge,
    // outputs are compared at the following falling edge.
    task automatic cycle(input string tag);
        @(posedge clk);
        if (!rst_n || init) begin
            m_opc = '0; m_ip = '0; m_dp = '0;
        end else if (retire && !ctrl) begin
            m_opc = {b0[2:0], b1};
            m_ip  = ref_ptr(mode, csel, coff, cbase);
            if (mem_valid) m_dp = ref_ptr(mode, dsel, doff, dbase);
        end
        @(negedge clk);
        chk({tag, " opcode"}, 64'(opc_o), 64'(m_opc));
        chk({tag, " ip"}, ip_o, m_ip);
        chk({tag, " dp"}, dp_o, m_dp);
    endtask

    task automatic idle_inputs();
        retire = 0; ctrl = 0; mem_valid = 0; init = 0;
    endtask

    task automatic scramble();
        b0 = 8'($urandom); b1 = 8'($urandom); mode = 2'($urandom);
        csel = 16'($urandom); dsel = 16'($urandom);
        coff = {$urandom, $urandom}; cbase = {$urandom, $urandom};
        doff = {$urandom, $urandom}; dbase = {$urandom, $urandom};
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 0; idle_inputs(); scramble();
        m_opc = '0; m_ip = '0; m_dp = '0;
        @(negedge clk);
        cycle("R1"); cycle("R1");
        rst_n = 1;

        // R2 + R4: D9 F8 in 64-bit mode with a memory operand.
        b0 = 8'hD9; b1 = 8'hF8; mode = 2'b00; csel = 16'hABCD;
        coff = 64'hFEDC_BA98_7654_3210; cbase = 64'h1111_2222_3333_4444;
        doff = 64'h8000_0000_0000_0001; dsel = 16'h5555;
        retire = 1; mem_valid = 1;
        cycle("R10");
        chk("R2 D9F8", 64'(opc_o), 64'h1F8);
        chk("R4 full offset", ip_o, 64'hFEDC_BA98_7654_3210);
        chk("R7 long dp", dp_o, 64'h8000_0000_0000_0001);

        // R5: protected layout.
        mode = 2'b01; b0 = 8'hDF; b1 = 8'h07;
        cycle("R5");
        chk("R5 ip", ip_o, 64'h0000_ABCD_7654_3210);
        chk("R5 dp", dp_o, 64'h0000_5555_0000_0001);
        chk("R2 top bits dropped", 64'(opc_o), 64'h707);

        // R6: real-mode linear address and 32-bit wrap.
        mode = 2'b10; cbase = 64'hFFFF_0000_0001_2340; coff = 64'h0000_0001_0000_0005;
        mem_valid = 0;
        cycle("R6");
        chk("R6 lin", ip_o, 64'h0000_0000_0001_2345);
        chk("R7 dp held no mem", dp_o, 64'h0000_5555_0000_0001);
        mode = 2'b11; cbase = 64'hFFFF_FFF0; coff = 64'h20;
        cycle("R6");
        chk("R6 wrap", ip_o, 64'h10);

        // R3: control instructions with everything else changed.
        ctrl = 1; mem_valid = 1;
        for (int i = 0; i < 6; i++) begin scramble(); cycle("R3"); end
        chk("R3 ip kept", ip_o, 64'h10);
        ctrl = 0;

        // R7: data pointer survives non-memory captures in other modes.
        mem_valid = 0;
        for (int i = 0; i < 6; i++) begin scramble(); cycle("R7"); end
        chk("R7 dp kept", dp_o, 64'h0000_5555_0000_0001);

        // R9: idle with scrambled inputs.
        retire = 0; mem_valid = 1;
        for (int i = 0; i < 6; i++) begin scramble(); cycle("R9"); end

        // R8: init together with a retire.
        retire = 1; init = 1; scramble();
        cycle("R8");
        chk("R8 ip zero", ip_o, 64'h0);
        chk("R8 dp zero", dp_o, 64'h0);
        chk("R8 opc zero", 64'(opc_o), 64'h0);
        init = 0;

        // Random phase against the model.
        for (int i = 0; i < 400; i++) begin
            scramble();
            retire = 1'($urandom); ctrl = ($urandom % 4) == 0;
            mem_valid = 1'($urandom); init = ($urandom % 25) == 0;
            rst_n = ($urandom % 60) != 0;
            cycle("R10");
        end
        rst_n = 1; idle_inputs();
        cycle("R9");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule